// File: doc/BRIEF.md
# Converter Control Serial Slave

This block is the two-wire serial (I2C) slave front end of a multi-channel data converter. It oversamples the bus clock and data lines in the system clock domain, recognises START, repeated START and STOP, and answers to a 7-bit address. The upper five address bits are a fixed prefix. The lower two come from strap pins, which are read once after reset so that up to four converters can share one bus.

A write transfer loads a command byte that drives the converter controls: a single-ended/differential select, a 3-bit channel number and a 2-bit power mode. A read transfer returns the converter result from a 16-bit parallel input. The high byte comes first, and every later byte repeats the low byte. The block never drives the data line high. It only outputs a pull-down enable for an external open-drain pad.

The controller is one state machine with eight states:

| State | Role |
|---|---|
| IDLE | Bus free |
| ADDR | Shifting in the address byte |
| ADDR_ACK | Acknowledging the address |
| WR_DATA | Shifting in a command byte |
| WR_ACK | Acknowledging a command byte |
| RD_DATA | Shifting out a result byte |
| RD_ACK | Sampling the master's acknowledge |
| SKIP | Ignoring the bus until the next START |

Transitions:
- Any state goes to ADDR on START, and to IDLE on STOP.
- ADDR goes to ADDR_ACK on an address match, or to SKIP on a mismatch. This happens on the SCL fall after the eighth bit.
- ADDR_ACK goes to WR_DATA or RD_DATA on the SCL fall, depending on the direction bit.
- WR_DATA goes to WR_ACK after eight bits, and WR_ACK returns to WR_DATA on the SCL fall.
- RD_DATA goes to RD_ACK after eight bits. RD_ACK goes back to RD_DATA when the master acknowledges, or to SKIP when it does not.

Top module: `conv_i2c_front`

## Requirements
- R1: After reset, `sda_pull` is 0 and `cmd_se`, `cmd_chan` and `cmd_pwr` are all 0.
- R2: The slave acknowledges an address byte sent MSB first as 1,0,0,1,0, then strap bit 1, then strap bit 0, then R/W (1 = read, 0 = write). To acknowledge, it holds `sda_pull` high through the whole SCL-high phase of the ninth clock.
- R3: `sel_pins` are captured in the first cycle after reset and then held. Changing them later does not change which address is acknowledged.
- R4: On an address mismatch the slave gives no acknowledge. It then ignores all bytes and does not change the command outputs until the next START.
- R5: The slave releases `sda_pull` after the SCL falling edge that ends an acknowledge clock.
- R6: In a write, every data byte is acknowledged. The byte maps bit 7 to `cmd_se`, bits 6..4 to `cmd_chan` and bits 3..2 to `cmd_pwr`; bits 1..0 are ignored.
- R7: The command outputs update only once all eight bits of a data byte have arrived. A later byte in the same write overwrites them, and a byte cut short by STOP or START leaves them unchanged.
- R8: `result_in` is captured when a read address matches. The slave then sends the captured bits 15..8, then bits 7..0, and repeats bits 7..0 for every further byte the master acknowledges. All bytes go MSB first.
- R9: After the master sends a not-acknowledge, the slave releases the data line and drives nothing until the next START.
- R10: A repeated START, including one in the middle of a byte, restarts address reception without passing through idle.
- R11: After STOP the slave is idle and does not respond to clocked bytes that have no START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sel_pins | input | 2 | Address strap pins, sampled after reset |
| result_in | input | 16 | Parallel conversion result |
| sda_pull | output | 1 | Open-drain pull-down enable for the data line |
| cmd_se | output | 1 | Single-ended (1) / differential (0) select |
| cmd_chan | output | 3 | Channel select |
| cmd_pwr | output | 2 | Power mode bits |

## Verification
The hardest case to reach is a START or STOP arriving partway through a byte. The bench's master tasks can send a partial byte of chosen length and then issue a repeated START or STOP. This shows that half-received bytes are discarded and that address reception restarts cleanly. A second hard case is the read path after a NACK, which is reached by clocking further bytes from the master and checking that the line stays high. The capture point of the result is also tested: `result_in` is changed right after the address acknowledge, and the bench checks that the returned bytes still hold the old value.

// File: rtl/conv_i2c_pkg.sv
package conv_i2c_pkg;
    localparam int BYTE_BITS = 8;
    localparam int SEL_W     = 2;
    localparam int PREFIX_W  = 7 - SEL_W;
    localparam logic [PREFIX_W-1:0] ADDR_PREFIX = 5'b10010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_SKIP
    } slave_state_e;

    typedef struct packed {
        logic       se;
        logic [2:0] chan;
        logic [1:0] pwr;
    } cmd_fields_t;
endpackage

// File: rtl/i2c_bus_sampler.sv
module i2c_bus_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sync_q, sda_sync_q;
    logic                   scl_prev_q, sda_prev_q;
    logic                   scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sync_q <= '1;
            sda_sync_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_sync_q <= {scl_sync_q[SYNC_STAGES-2:0], scl_in};
            sda_sync_q <= {sda_sync_q[SYNC_STAGES-2:0], sda_in};
            scl_prev_q <= scl_sync_q[SYNC_STAGES-1];
            sda_prev_q <= sda_sync_q[SYNC_STAGES-1];
        end
    end

    assign scl_s     = scl_sync_q[SYNC_STAGES-1];
    assign sda_s     = sda_sync_q[SYNC_STAGES-1];
    assign scl_rise  = scl_s & ~scl_prev_q;
    assign scl_fall  = ~scl_s & scl_prev_q;
    assign start_det = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_det  = scl_s & scl_prev_q & ~sda_prev_q & sda_s;
endmodule

// File: rtl/conv_cmd_reg.sv
module conv_cmd_reg
    import conv_i2c_pkg::*;
#(
    parameter int DATA_W = BYTE_BITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_byte,
    output cmd_fields_t       cmd
);
    localparam int FIELD_W = $bits(cmd_fields_t);

    cmd_fields_t cmd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cmd_q <= '0;
        else if (wr_en)
            cmd_q <= cmd_fields_t'(wr_byte[DATA_W-1 -: FIELD_W]);
    end

    assign cmd = cmd_q;

    // R7: command holds unless a full byte was written
    a_r7_cmd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(wr_en) |-> $stable(cmd_q));
endmodule

// File: rtl/conv_slave_fsm.sv
module conv_slave_fsm
    import conv_i2c_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [SEL_W-1:0]     sel_pins,
    input  logic [RES_W-1:0]     result_in,
    input  logic                 scl_rise,
    input  logic                 scl_fall,
    input  logic                 sda_s,
    input  logic                 start_det,
    input  logic                 stop_det,
    output logic                 sda_pull,
    output logic                 cmd_we,
    output logic [BYTE_BITS-1:0] cmd_byte
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_BITS);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(BYTE_BITS - 1);

    slave_state_e          state_q, state_d;
    logic [CNT_W-1:0]      cnt_q;
    logic [BYTE_BITS-1:0]  sh_q, tx_q;
    logic [RES_W-1:0]      res_q;
    logic [SEL_W-1:0]      sel_q;
    logic                  sel_ok_q, rw_q, mack_q;
    logic                  addr_hit, byte_done;

    assign addr_hit  = (sh_q[BYTE_BITS-1:1] == {ADDR_PREFIX, sel_q});
    assign byte_done = scl_fall && (cnt_q == CNT_FULL);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (start_det)
            state_d = ST_ADDR;
        else if (stop_det)
            state_d = ST_IDLE;
        else begin
            unique case (state_q)
                ST_IDLE, ST_SKIP: state_d = state_q;
                ST_ADDR:     if (byte_done) state_d = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall)  state_d = rw_q ? ST_RD_DATA : ST_WR_DATA;
                ST_WR_DATA:  if (byte_done) state_d = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)  state_d = ST_WR_DATA;
                ST_RD_DATA:  if (scl_fall && cnt_q == CNT_LAST) state_d = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)  state_d = mack_q ? ST_RD_DATA : ST_SKIP;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // strap capture, once after reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q    <= '0;
            sel_ok_q <= 1'b0;
        end else if (!sel_ok_q) begin
            sel_q    <= sel_pins;
            sel_ok_q <= 1'b1;
        end
    end

    // datapath: bit counter, shifters, captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            sh_q   <= '0;
            tx_q   <= '1;
            res_q  <= '0;
            rw_q   <= 1'b0;
            mack_q <= 1'b0;
        end else if (start_det || stop_det) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_ADDR, ST_WR_DATA: begin
                    if (scl_rise && cnt_q < CNT_FULL) begin
                        sh_q  <= {sh_q[BYTE_BITS-2:0], sda_s};
                        cnt_q <= cnt_q + 1'b1;
                    end
                    if (state_q == ST_ADDR && byte_done && addr_hit) begin
                        rw_q  <= sh_q[0];
                        res_q <= result_in;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt_q <= '0;
                        tx_q  <= res_q[RES_W-1 -: BYTE_BITS];
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) cnt_q <= '0;
                end
                ST_RD_DATA: begin
                    if (scl_fall) begin
                        if (cnt_q == CNT_LAST) begin
                            cnt_q <= '0;
                        end else begin
                            tx_q  <= {tx_q[BYTE_BITS-2:0], 1'b1};
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mack_q <= ~sda_s;
                    if (scl_fall) begin
                        tx_q  <= res_q[BYTE_BITS-1:0];
                        cnt_q <= '0;
                    end
                end
                ST_IDLE, ST_SKIP: cnt_q <= '0;
                default: cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull = 1'b0;
        cmd_we   = 1'b0;
        cmd_byte = sh_q;
        unique case (state_q)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull = 1'b1;
            ST_RD_DATA:             sda_pull = ~tx_q[BYTE_BITS-1];
            ST_WR_DATA:             cmd_we   = byte_done && !start_det && !stop_det;
            default:                sda_pull = 1'b0;
        endcase
    end

    // R10: START always restarts address reception from bit zero
    a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state_q == ST_ADDR && cnt_q == '0));

    // R11: STOP returns to idle
    a_r11_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && !start_det) |=> (state_q == ST_IDLE && !sda_pull));

    // R5: acknowledge is held until the SCL fall
    a_r5_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_ADDR_ACK || state_q == ST_WR_ACK) && !scl_fall && !start_det && !stop_det)
        |=> sda_pull);

    // R3: straps never change once captured
    a_r3_sel_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_ok_q && $past(sel_ok_q)) |-> $stable(sel_q));

    // R4: an ignored transfer never pulls the line on the next cycle
    a_r4_skip_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SKIP && !start_det) |=> !sda_pull);
endmodule

// File: rtl/conv_i2c_front.sv
module conv_i2c_front
    import conv_i2c_pkg::*;
#(
    parameter int RES_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    input  logic [SEL_W-1:0] sel_pins,
    input  logic [RES_W-1:0] result_in,
    output logic             sda_pull,
    output logic             cmd_se,
    output logic [2:0]       cmd_chan,
    output logic [1:0]       cmd_pwr
);
    logic                 scl_rise, scl_fall, sda_s, start_det, stop_det;
    logic                 cmd_we;
    logic [BYTE_BITS-1:0] cmd_byte;
    cmd_fields_t          cmd;

    i2c_bus_sampler #(.SYNC_STAGES(2)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    conv_slave_fsm #(.RES_W(RES_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_pins  (sel_pins),
        .result_in (result_in),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det),
        .sda_pull  (sda_pull),
        .cmd_we    (cmd_we),
        .cmd_byte  (cmd_byte)
    );

    conv_cmd_reg #(.DATA_W(BYTE_BITS)) u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cmd_we),
        .wr_byte (cmd_byte),
        .cmd     (cmd)
    );

    assign cmd_se   = cmd.se;
    assign cmd_chan = cmd.chan;
    assign cmd_pwr  = cmd.pwr;
endmodule

// File: tb/test_conv_i2c_front.sv
module test_conv_i2c_front;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic [1:0]  sel_pins = 2'b10;
    logic [15:0] result_in = 16'h0000;
    logic        sda_pull, cmd_se;
    logic [2:0]  cmd_chan;
    logic [1:0]  cmd_pwr;
    logic        sda_line;

    assign sda_line = m_sda & ~sda_pull;

    always #2.5 clk = ~clk;

    conv_i2c_front i_conv_i2c_front (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (m_scl),
        .sda_in    (sda_line),
        .sel_pins  (sel_pins),
        .result_in (result_in),
        .sda_pull  (sda_pull),
        .cmd_se    (cmd_se),
        .cmd_chan  (cmd_chan),
        .cmd_pwr   (cmd_pwr)
    );

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    string exp_req[$];
    int    exp_val[$];
    int    obs_val[$];

    // scoreboard: driver pushes expected/observed, monitor compares
    task automatic push(input string req, input int expv, input int actv);
        exp_req.push_back(req);
        exp_val.push_back(expv);
        obs_val.push_back(actv);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (obs_val.size() > 0) begin
                string r;
                int e;
                int a;
                r = exp_req.pop_front();
                e = exp_val.pop_front();
                a = obs_val.pop_front();
                n_checks++;
                if (a != e) begin
                    n_fail++;
                    $display("FAIL %s: actual %0h expected %0h", r, a, e);
                end
            end
        end
    end

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input logic b, output logic s);
        wait_q(Q); m_sda = b;
        wait_q(Q); m_scl = 1'b1;
        wait_q(Q); s = sda_line;
        wait_q(Q); m_scl = 1'b0;
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b0; wait_q(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wait_q(Q);
        m_scl = 1'b1; wait_q(Q);
        m_sda = 1'b1; wait_q(2*Q);
    endtask

    task automatic write_byte(input logic [7:0] b, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = ~s;
    endtask

    task automatic read_byte(input logic mack, output logic [7:0] d);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            clock_bit(1'b1, s);
            d[i] = s;
        end
        clock_bit(~mack, s);
    endtask

    function automatic int cmd_now();
        return {26'd0, cmd_se, cmd_chan, cmd_pwr};
    endfunction

    initial begin
        logic       ack;
        logic       s;
        logic [7:0] d;

        wait_q(4);
        rst_n = 1'b1;
        wait_q(4);
        // R1: reset state
        push("R1 pull", 0, int'(sda_pull));
        push("R1 cmd", 0, cmd_now());

        // R2/R5/R6: write one command byte
        bus_start();
        write_byte(8'h94, ack);
        push("R2 addr ack", 1, int'(ack));
        wait_q(8);
        push("R5 release", 0, int'(sda_pull));
        write_byte(8'hB7, ack);
        push("R6 data ack", 1, int'(ack));
        bus_stop();
        push("R6 fields", 8'hB7 >> 2, cmd_now());

        // R7: later byte overwrites
        bus_start();
        write_byte(8'h94, ack);
        write_byte(8'h4A, ack);
        push("R7 mid", 8'h4A >> 2, cmd_now());
        write_byte(8'hE1, ack);
        push("R6 second ack", 1, int'(ack));
        bus_stop();
        push("R7 overwrite", 8'hE1 >> 2, cmd_now());

        // R7: byte cut short by STOP
        bus_start();
        write_byte(8'h94, ack);
        for (int i = 0; i < 4; i++) clock_bit(i[0], s);
        bus_stop();
        push("R7 partial", 8'hE1 >> 2, cmd_now());

        // R4: wrong select bits
        bus_start();
        write_byte(8'h96, ack);
        push("R4 addr nack", 0, int'(ack));
        write_byte(8'h00, ack);
        push("R4 data nack", 0, int'(ack));
        bus_stop();
        push("R4 cmd kept", 8'hE1 >> 2, cmd_now());

        // R8/R9: read with capture point
        result_in = 16'hA55A;
        bus_start();
        write_byte(8'h95, ack);
        push("R2 read ack", 1, int'(ack));
        result_in = 16'h1234;
        read_byte(1'b1, d);
        push("R8 high", 8'hA5, int'(d));
        read_byte(1'b1, d);
        push("R8 low", 8'h5A, int'(d));
        read_byte(1'b0, d);
        push("R8 repeat low", 8'h5A, int'(d));
        wait_q(8);
        push("R9 released", 0, int'(sda_pull));
        read_byte(1'b0, d);
        push("R9 no drive", 8'hFF, int'(d));
        bus_stop();

        // R10: repeated START write then read
        bus_start();
        write_byte(8'h94, ack);
        write_byte(8'h10, ack);
        push("R10 wr cmd", 8'h10 >> 2, cmd_now());
        bus_start();
        write_byte(8'h95, ack);
        push("R10 reread ack", 1, int'(ack));
        read_byte(1'b0, d);
        push("R10 read", 8'h12, int'(d));
        bus_stop();

        // R10: repeated START mid-byte
        bus_start();
        write_byte(8'h94, ack);
        for (int i = 0; i < 3; i++) clock_bit(1'b1, s);
        bus_start();
        push("R10 partial kept", 8'h10 >> 2, cmd_now());
        write_byte(8'h94, ack);
        push("R10 restart ack", 1, int'(ack));
        write_byte(8'h5C, ack);
        bus_stop();
        push("R10 new cmd", 8'h5C >> 2, cmd_now());

        // R3: straps changed after reset are ignored
        sel_pins = 2'b01;
        bus_start();
        write_byte(8'h92, ack);
        push("R3 new strap nack", 0, int'(ack));
        bus_stop();
        bus_start();
        write_byte(8'h94, ack);
        push("R3 old strap ack", 1, int'(ack));
        bus_stop();

        // R11: idle after STOP, no START
        m_scl = 1'b0;
        write_byte(8'h94, ack);
        push("R11 no start", 0, int'(ack));
        bus_stop();
        push("R11 pull idle", 0, int'(sda_pull));

        while (obs_val.size() > 0) wait_q(1);
        wait_q(2);
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule